// File: doc/BRIEF.md
# Oversampling ADC Conversion Sequencer and Result Formatter

This block runs the digital side of an oversampling converter. A sampling enable at one of two rates (a fast 6 MHz rate or a slow 1 MHz rate) is divided down from the system clock. The divider ratio follows an input that says whether the system clock is the nominal 24 MHz source or the nominal 12 MHz source, so conversion timing is the same on either source. Each conversion adds up the multi-bit modulator code over 32·2^N sampling enables. N is a 3-bit period setting.

The sum is reduced to 7+N significant bits and placed at the top of a 16-bit word, with all lower bits zero. The word is then read as offset binary and turned into two's complement. It is multiplied by an unsigned gain (0x8000 = 1.0), an offset is added, and the value is clamped to signed 16 bits.

The result leaves on a one-cycle valid strobe. There is no ready signal and no back-pressure. The DMA enable input stands in for the consumer: a result delivered while it is low is lost, and the overflow flag records the loss. Two sticky flags and an interrupt enable with separate set and clear strobes produce the interrupt output.

Top module: `adc_seq`

## Requirements
- R1: While `run` is high and no conversion is in progress, the block starts a conversion on the next clock. The conversion ends on the 32·2^N-th selected sampling enable. `res_valid` rises on the following clock and is high for exactly one cycle.
- R2: Before gain correction, the word is (sum >> 2) shifted left by 9−N. Its low 9−N bits are always zero. Bit 15 is then inverted to give a two's-complement value.
- R3: With `cfg_slow` = 0, a sample is taken every 4 clocks (`osc_slow` = 0) or every 2 clocks (`osc_slow` = 1). With `cfg_slow` = 1, a sample is taken every 24 or 12 clocks.
- R4: `cfg_period` and `cfg_slow` are captured when a conversion starts. Changing them mid-conversion has no effect on that conversion.
- R5: `res_data` = clamp(floor(s·gain / 2^15) + offset), where s is the signed word and `offset` is signed.
- R6: Flag bit 1 (saturation) is set when the clamp in R5 limits a result.
- R7: Flag bit 0 (overflow) is set when a result is delivered while `dma_en` is low.
- R8: Flags stay set until `flag_clr_we` is asserted with a 1 in the matching bit of `wdata`. A zero bit leaves its flag as it is. A new event in the same cycle wins over the clear.
- R9: `en_set_we` with `wdata[0]`=1 sets `irq_en`. `en_clr_we` with `wdata[0]`=1 clears it, and the clear wins if both happen in the same cycle. A write with `wdata[0]`=0 has no effect.
- R10: `irq` is high exactly when `irq_en` is high and at least one flag is set.
- R11: After reset, `res_valid`, `flags`, `irq_en` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_slow | input | 1 | 1 = system clock is the 12 MHz source, 0 = 24 MHz |
| run | input | 1 | Start conversions while high |
| cfg_period | input | 3 | Period setting N |
| cfg_slow | input | 1 | 1 = 1 MHz sampling, 0 = 6 MHz |
| mod_in | input | 4 | Modulator output code |
| dma_en | input | 1 | Consumer accepts results |
| gain | input | 16 | Unsigned gain, 0x8000 = 1.0 |
| offset | input | 16 | Signed offset |
| flag_clr_we | input | 1 | Write-one-to-clear strobe for flags |
| en_set_we | input | 1 | Interrupt enable set strobe |
| en_clr_we | input | 1 | Interrupt enable clear strobe |
| wdata | input | 2 | Write data for the three strobes |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Corrected result |
| flags | output | 2 | bit0 overflow, bit1 saturation |
| irq_en | output | 1 | Interrupt enable state |
| irq | output | 1 | Interrupt request |

## Verification
Faults inside the block surface at the ports in two ways.

- **Counter or capture faults.** A wrong sampling-enable counter or a mis-captured period moves the result strobe. The error shows within a single conversion, between 64 and 98,304 clocks after the start depending on settings. The per-clock reference model catches a strobe that is early or late by even one cycle.
- **Accumulator, alignment or gain faults.** These show up in the value carried on the strobe, including the zero low bits at unity gain. Flag and enable faults show on the next clock after the event or write, through `flags`, `irq_en` and `irq`.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int OUT_W    = 16;
  localparam int BASE_LOG = 5;   // 32 samples at period 0
  localparam int SIG_BASE = 7;   // significant bits at period 0
  localparam int FLAG_OVF = 0;
  localparam int FLAG_SAT = 1;
  localparam int NFLAGS   = 2;

  typedef struct packed {
    logic [2:0] period;
    logic       slow;
  } conv_cfg_t;
endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
  parameter int SYS_HI_MHZ  = 24,
  parameter int SYS_LO_MHZ  = 12,
  parameter int RATE_FAST   = 6,
  parameter int RATE_SLOW   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_slow,
  output logic [1:0] tick
);
  for (genvar i = 0; i < 2; i++) begin : g_div
    localparam int RATE = (i == 0) ? RATE_FAST : RATE_SLOW;
    localparam int DHI  = SYS_HI_MHZ / RATE;
    localparam int DLO  = SYS_LO_MHZ / RATE;
    localparam int CW   = $clog2(DHI + 1);
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    assign lim     = osc_slow ? CW'(DLO - 1) : CW'(DHI - 1);
    assign tick[i] = (cnt >= lim);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (tick[i]) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_conv.sv
module adc_seq_conv
  import adc_seq_pkg::*;
#(
  parameter int MOD_W = 4,
  parameter int PER_W = 3,
  localparam int PER_MAX = (1 << PER_W) - 1,
  localparam int CNT_W   = BASE_LOG + PER_MAX + 1,
  localparam int ACC_W   = MOD_W + BASE_LOG + PER_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  conv_cfg_t        cfg,
  input  logic [1:0]       tick,
  input  logic [MOD_W-1:0] mod_in,
  output logic             done,
  output logic [ACC_W-1:0] sum,
  output logic [PER_W-1:0] per_q
);
  logic             busy;
  logic             slow_q;
  logic [CNT_W-1:0] cnt;
  logic [ACC_W-1:0] acc;
  logic             tick_sel;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] cnt_nx;

  assign tick_sel = slow_q ? tick[1] : tick[0];
  assign total    = CNT_W'(1) << (BASE_LOG + int'(per_q));
  assign cnt_nx   = cnt + 1'b1;
  assign sum      = acc + ACC_W'(mod_in);
  assign done     = busy && tick_sel && (cnt_nx == total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slow_q <= 1'b0;
      per_q  <= '0;
      cnt    <= '0;
      acc    <= '0;
    end else if (!busy) begin
      if (run) begin
        busy   <= 1'b1;
        per_q  <= cfg.period;
        slow_q <= cfg.slow;
        cnt    <= '0;
        acc    <= '0;
      end
    end else if (tick_sel) begin
      acc <= sum;
      cnt <= cnt_nx;
      if (done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt
  import adc_seq_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int PER_W = 3,
  parameter int DROP  = 2
) (
  input  logic [ACC_W-1:0] sum,
  input  logic [PER_W-1:0] per,
  input  logic [OUT_W-1:0] gain,
  input  logic [OUT_W-1:0] offset,
  output logic [OUT_W-1:0] data,
  output logic             sat
);
  localparam int PW = 2 * OUT_W + 1;
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic [ACC_W-1:0]        top;
  logic [4:0]              shamt;
  logic [31:0]             wide;
  logic [OUT_W-1:0]        aligned;
  logic signed [OUT_W-1:0] s;
  logic signed [OUT_W:0]   g;
  logic signed [PW-1:0]    prod;
  logic signed [PW-1:0]    corr;

  always_comb begin
    top     = sum >> DROP;
    shamt   = 5'(OUT_W - SIG_BASE) - 5'(per);
    wide    = 32'(top) << shamt;
    aligned = wide[OUT_W-1:0];
    s       = $signed(aligned ^ (OUT_W'(1) << (OUT_W - 1)));
    g       = $signed({1'b0, gain});
    prod    = PW'(s) * PW'(g);
    corr    = (prod >>> (OUT_W - 1)) + PW'($signed(offset));
    sat     = 1'b0;
    if (corr > MAXV) begin
      data = {1'b0, {(OUT_W-1){1'b1}}};
      sat  = 1'b1;
    end else if (corr < MINV) begin
      data = {1'b1, {(OUT_W-1){1'b0}}};
      sat  = 1'b1;
    end else begin
      data = corr[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAGS-1:0] set_ev,
  input  logic              flag_clr_we,
  input  logic              en_set_we,
  input  logic              en_clr_we,
  input  logic [NFLAGS-1:0] wdata,
  output logic [NFLAGS-1:0] flags,
  output logic              irq_en,
  output logic              irq
);
  logic [NFLAGS-1:0] clr_mask;
  assign clr_mask = flag_clr_we ? wdata : '0;
  assign irq      = irq_en && (|flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      irq_en <= 1'b0;
    end else begin
      flags <= (flags & ~clr_mask) | set_ev;
      if (en_clr_we && wdata[0])      irq_en <= 1'b0;
      else if (en_set_we && wdata[0]) irq_en <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int MOD_W      = 4,
  parameter int PER_W      = 3,
  parameter int SYS_HI_MHZ = 24,
  parameter int SYS_LO_MHZ = 12,
  parameter int RATE_FAST  = 6,
  parameter int RATE_SLOW  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_slow,
  input  logic             run,
  input  logic [PER_W-1:0] cfg_period,
  input  logic             cfg_slow,
  input  logic [MOD_W-1:0] mod_in,
  input  logic             dma_en,
  input  logic [15:0]      gain,
  input  logic [15:0]      offset,
  input  logic             flag_clr_we,
  input  logic             en_set_we,
  input  logic             en_clr_we,
  input  logic [1:0]       wdata,
  output logic             res_valid,
  output logic [15:0]      res_data,
  output logic [1:0]       flags,
  output logic             irq_en,
  output logic             irq
);
  localparam int PER_MAX = (1 << PER_W) - 1;
  localparam int ACC_W   = MOD_W + BASE_LOG + PER_MAX;
  localparam int DROP    = MOD_W + BASE_LOG - SIG_BASE;

  logic [1:0]       tick;
  conv_cfg_t        cfg;
  logic             done;
  logic [ACC_W-1:0] sum;
  logic [PER_W-1:0] per_q;
  logic [15:0]      fmt_data;
  logic             fmt_sat;
  logic [1:0]       set_ev;

  assign cfg.period = 3'(cfg_period);
  assign cfg.slow   = cfg_slow;

  adc_seq_tick #(
    .SYS_HI_MHZ(SYS_HI_MHZ), .SYS_LO_MHZ(SYS_LO_MHZ),
    .RATE_FAST(RATE_FAST), .RATE_SLOW(RATE_SLOW)
  ) u_tick (.clk(clk), .rst_n(rst_n), .osc_slow(osc_slow), .tick(tick));

  adc_seq_conv #(.MOD_W(MOD_W), .PER_W(PER_W)) u_conv (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg(cfg), .tick(tick),
    .mod_in(mod_in), .done(done), .sum(sum), .per_q(per_q)
  );

  adc_seq_fmt #(.ACC_W(ACC_W), .PER_W(PER_W), .DROP(DROP)) u_fmt (
    .sum(sum), .per(per_q), .gain(gain), .offset(offset),
    .data(fmt_data), .sat(fmt_sat)
  );

  assign set_ev[FLAG_OVF] = done && !dma_en;
  assign set_ev[FLAG_SAT] = done && fmt_sat;

  adc_seq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .flag_clr_we(flag_clr_we),
    .en_set_we(en_set_we), .en_clr_we(en_clr_we), .wdata(wdata),
    .flags(flags), .irq_en(irq_en), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= done;
      if (done) res_data <= fmt_data;
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dma_en,
  input logic       flag_clr_we,
  input logic       en_set_we,
  input logic       en_clr_we,
  input logic [1:0] wdata,
  input logic       res_valid,
  input logic [1:0] flags,
  input logic       irq_en,
  input logic       irq
);
  a_r1_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r7_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(dma_en)) |-> flags[0]);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(flag_clr_we && wdata[0])) |=> flags[0]);

  a_r8_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !(flag_clr_we && wdata[1])) |=> flags[1]);

  a_r9_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set_we && wdata[0] && !en_clr_we) |=> irq_en);

  a_r9_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr_we && wdata[0]) |=> !irq_en);

  a_r9_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    !((en_set_we || en_clr_we) && wdata[0]) |=> $stable(irq_en));

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en || flags == 2'b00) |-> !irq);
endmodule

bind adc_seq adc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .flag_clr_we(flag_clr_we),
  .en_set_we(en_set_we), .en_clr_we(en_clr_we), .wdata(wdata),
  .res_valid(res_valid), .flags(flags), .irq_en(irq_en), .irq(irq)
);

// File: tb/adc_seq_test.sv
module adc_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_slow = 1'b0, run = 1'b0, cfg_slow = 1'b0, dma_en = 1'b1;
  logic [2:0] cfg_period = 3'd0;
  logic [3:0] mod_in = 4'd0;
  logic [15:0] gain = 16'h8000, offset = 16'h0000;
  logic flag_clr_we = 1'b0, en_set_we = 1'b0, en_clr_we = 1'b0;
  logic [1:0] wdata = 2'b00;
  logic res_valid, irq_en, irq;
  logic [15:0] res_data;
  logic [1:0] flags;

  int errors = 0, checks = 0;
  int mod_mode = 0;
  bit cmp_on = 1'b0;
  bit done_flag = 1'b0;
  string cur_tag = "R2";

  // reference model state
  int fcnt, scnt, mcnt, macc, mper;
  bit mbusy, mrate, m_valid, m_en;
  int m_flags;
  logic [15:0] m_data;

  adc_seq uut (
    .clk(clk), .rst_n(rst_n), .osc_slow(osc_slow), .run(run),
    .cfg_period(cfg_period), .cfg_slow(cfg_slow), .mod_in(mod_in),
    .dma_en(dma_en), .gain(gain), .offset(offset),
    .flag_clr_we(flag_clr_we), .en_set_we(en_set_we), .en_clr_we(en_clr_we),
    .wdata(wdata), .res_valid(res_valid), .res_data(res_data),
    .flags(flags), .irq_en(irq_en), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] calc(input int acc, input int per,
                                       output bit sat);
    longint top, fmt, s, p, v;
    top = acc >> 2;
    fmt = (top << (9 - per)) & 16'hFFFF;
    s = fmt - 32768;
    p = (s * longint'(gain)) >>> 15;
    v = p + longint'($signed(offset));
    sat = 1'b0;
    if (v > 32767) begin v = 32767; sat = 1'b1; end
    if (v < -32768) begin v = -32768; sat = 1'b1; end
    return v[15:0];
  endfunction

  always @(posedge clk) begin
    bit ft, st, sat;
    int nf;
    if (!rst_n) begin
      fcnt = 0; scnt = 0; mcnt = 0; macc = 0; mper = 0;
      mbusy = 0; mrate = 0; m_valid = 0; m_en = 0; m_flags = 0; m_data = 0;
    end else begin
      ft = fcnt >= (osc_slow ? 2 : 4) - 1;
      st = scnt >= (osc_slow ? 12 : 24) - 1;
      fcnt = ft ? 0 : fcnt + 1;
      scnt = st ? 0 : scnt + 1;
      m_valid = 0;
      nf = m_flags;
      if (flag_clr_we) nf = nf & ~int'(wdata);
      if (!mbusy) begin
        if (run) begin
          mbusy = 1; mper = cfg_period; mrate = cfg_slow; mcnt = 0; macc = 0;
        end
      end else if (mrate ? st : ft) begin
        macc += mod_in;
        mcnt++;
        if (mcnt == (32 << mper)) begin
          mbusy = 0; m_valid = 1;
          m_data = calc(macc, mper, sat);
          if (!dma_en) nf |= 1;
          if (sat) nf |= 2;
        end
      end
      m_flags = nf;
      if (en_clr_we && wdata[0]) m_en = 0;
      else if (en_set_we && wdata[0]) m_en = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done_flag) begin
      chk("R1 result strobe timing", res_valid, m_valid);
      if (res_valid && m_valid) begin
        chk({cur_tag, " result value"}, res_data, m_data);
        if (cur_tag == "R2")
          chk("R2 low bits zero", res_data & ((16'd1 << (9 - mper)) - 1), 0);
      end
      chk({cur_tag, " flags"}, flags, m_flags);
      chk("R9 enable state", irq_en, m_en);
      chk("R10 interrupt", irq, m_en && (m_flags != 0));
    end
  end

  always @(negedge clk) begin
    case (mod_mode)
      0: mod_in <= 4'($urandom_range(0, 15));
      1: mod_in <= 4'd15;
      default: mod_in <= 4'd0;
    endcase
  end

  task automatic convert(input int n);
    int seen = 0;
    @(negedge clk);
    run = 1'b1;
    while (seen < n) begin
      @(negedge clk);
      if (res_valid) seen++;
    end
    run = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input bit c, input bit s, input bit e, input logic [1:0] d);
    @(negedge clk);
    flag_clr_we = c; en_set_we = s; en_clr_we = e; wdata = d;
    @(negedge clk);
    flag_clr_we = 0; en_set_we = 0; en_clr_we = 0; wdata = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 valid after reset", res_valid, 0);
    chk("R11 flags after reset", flags, 0);
    chk("R11 enable after reset", irq_en, 0);
    chk("R11 irq after reset", irq, 0);
    cmp_on = 1'b1;

    // R2: alignment across every period at unity gain, fast rate
    cur_tag = "R2"; osc_slow = 1;
    for (int n = 0; n < 8; n++) begin
      cfg_period = 3'(n);
      convert(1);
    end
    osc_slow = 0; cfg_period = 1;
    convert(2);

    // R3: slow sampling on both system clock sources
    cur_tag = "R3"; cfg_slow = 1; cfg_period = 0;
    convert(1);
    osc_slow = 1;
    convert(1);
    cfg_slow = 0;

    // R4: settings changed mid-conversion
    cur_tag = "R4"; osc_slow = 0; cfg_period = 2;
    @(negedge clk); run = 1'b1;
    repeat (3) @(negedge clk);
    run = 1'b0;
    repeat (60) @(negedge clk);
    cfg_period = 0; cfg_slow = 1;
    repeat (600) @(negedge clk);
    cfg_slow = 0;
    convert(1);

    // R5: non-saturating gain and negative offset
    cur_tag = "R5"; gain = 16'h4000; offset = 16'hFF9C; osc_slow = 1; cfg_period = 3;
    convert(2);
    chk("R5 no saturation flag", flags[1], 0);

    // R6: saturation high and low
    cur_tag = "R6"; mod_mode = 1; gain = 16'hFFFF; offset = 0; cfg_period = 0;
    convert(1);
    chk("R6 clamp high", res_data, 16'h7FFF);
    chk("R6 saturation flag", flags[1], 1);
    mod_mode = 2;
    convert(1);
    chk("R6 clamp low", res_data, 16'h8000);
    mod_mode = 0; gain = 16'h8000;

    // R7: overflow when DMA disabled
    cur_tag = "R7"; dma_en = 0;
    convert(1);
    chk("R7 overflow flag", flags[0], 1);
    dma_en = 1;

    // R8: write-one-to-clear, zeros ignored
    cur_tag = "R8";
    wr(1, 0, 0, 2'b00);
    chk("R8 zero write keeps flags", flags, 2'b11);
    wr(1, 0, 0, 2'b01);
    chk("R8 clear overflow only", flags, 2'b10);

    // R9 / R10: enable set and clear strobes
    wr(0, 1, 0, 2'b00);
    chk("R9 zero set ignored", irq_en, 0);
    wr(0, 1, 0, 2'b01);
    chk("R9 set", irq_en, 1);
    chk("R10 irq with flag", irq, 1);
    wr(0, 0, 1, 2'b00);
    chk("R9 zero clear ignored", irq_en, 1);
    wr(1, 0, 0, 2'b10);
    chk("R10 irq drops with flags", irq, 0);
    wr(0, 1, 1, 2'b01);
    chk("R9 clear wins", irq_en, 0);

    repeat (4) @(negedge clk);
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done_flag = 1'b1;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule